// File: doc/BRIEF.md
# CPU Status Flag Register

This block holds the eight-bit status word of a small eight-bit processor core. It also evaluates the result of the current operation. An operation is presented with an operation-class code, two operand bytes, a rotate carry-in and, for a bit test, a memory byte. The block drives the computed result combinationally. When the operation strobe is high, it loads the status flags on the next rising clock edge. Each flag follows its own rule for each operation class.

Three outputs serve the rest of the core:
- An interrupt gate. Maskable interrupt requests are combined with this gate.
- The ninth bit of the direct-page address.
- The status word itself.

An interrupt-accept strobe clears the interrupt-enable flag at the edge where an interrupt is taken, whether or not an operation is present.

The operation interface is a plain strobe with no back-pressure. Every cycle in which `op_valid` is high commits exactly one operation at the next edge, and the block can never refuse one. With `op_valid` low, the status word changes only through the interrupt-accept strobe.

Top module: `cpu_status_reg`

## Requirements
- R1: After reset the status word is 0x00. From bit 7 down to bit 0 it holds negative, overflow, page, break, half-carry, interrupt-enable, zero and carry.
- R2: Add (code 4'h1) gives result (a+b) mod 256 and loads C with the carry out. V is set on signed overflow and cleared otherwise. N takes result bit 7 and Z is set when the result is 0. H is set when bit 3 carries out and is otherwise left unchanged.
- R3: Subtract (code 4'h2) gives result (a-b) mod 256 and sets C to 1 when no borrow occurs (a >= b unsigned). V is set on signed overflow and cleared otherwise. N and Z follow the result. H is set when a[3:0] >= b[3:0] and is otherwise left unchanged.
- R4: Shift left (4'h3) outputs a<<1. Shift right (4'h4) outputs a>>1. Rotate left (4'h5) outputs {a[6:0], carry-in}. In each case C takes the bit shifted out and N and Z follow the result, while V and H are unchanged.
- R5: Transfer (4'h6) outputs operand a and updates only N and Z from it.
- R6: Bit test (4'h7) outputs a AND mem. It copies mem bit 7 into N and mem bit 6 into V, and sets Z when a AND mem is 0. C and H are unchanged.
- R7: EI (4'h8) sets the interrupt-enable flag and DI (4'h9) clears it. `irq_gate` equals that flag.
- R8: A high `irq_accept` clears the interrupt-enable flag at that edge, with or without `op_valid`. It wins over an EI in the same cycle.
- R9: Half-carry is cleared only by CLRV (4'hC), which also clears V. No operation other than add or subtract sets H.
- R10: SETG (4'hA) sets the page flag and CLRG (4'hB) clears it. `dp_page_bit` equals that flag.
- R11: BRK (4'hD) sets the break flag. Only reset clears it.
- R12: With `op_valid` low and `irq_accept` low, the status word holds. Code 4'h0 changes no flag. For codes 4'h8 to 4'hD the result equals operand a.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Commit the presented operation at the next edge |
| op_code | input | 4 | Operation class code |
| opnd_a | input | 8 | First operand (accumulator side) |
| opnd_b | input | 8 | Second operand |
| rot_cin | input | 1 | Bit shifted in by rotate left |
| mem_byte | input | 8 | Memory byte for the bit test |
| irq_accept | input | 1 | An interrupt is being taken this cycle |
| status | output | 8 | Status word N V G B H I Z C |
| result | output | 8 | Combinational result of the presented operation |
| irq_gate | output | 1 | Enable for maskable interrupt requests |
| dp_page_bit | output | 1 | Address bit 8 for direct addressing |

## Verification
Adds are driven with patterns that separate the three carry-style flags:
- a low-nibble carry without a byte carry;
- a positive-to-negative signed overflow;
- a wrap to zero with carry out and no overflow.

Subtracts cover equal operands, a borrow from zero, and a negative-to-positive overflow, each with and without a low-nibble borrow. This shows that H is only ever set by arithmetic and that C means "no borrow". Shifts and rotates are driven with a set bit at the edge being shifted out. Bit tests use memory bytes whose top bits differ from the AND result, so copied flags cannot be confused with computed ones. Directed cases pit interrupt accept against EI in the same cycle, and check that the word holds while no operation is presented.

// File: rtl/cpu_status_pkg.sv
package cpu_status_pkg;

  typedef enum logic [3:0] {
    OP_NOP  = 4'h0,
    OP_ADD  = 4'h1,
    OP_SUB  = 4'h2,
    OP_SHL  = 4'h3,
    OP_SHR  = 4'h4,
    OP_ROL  = 4'h5,
    OP_MOV  = 4'h6,
    OP_BIT  = 4'h7,
    OP_EI   = 4'h8,
    OP_DI   = 4'h9,
    OP_SETG = 4'hA,
    OP_CLRG = 4'hB,
    OP_CLRV = 4'hC,
    OP_BRK  = 4'hD
  } op_e;

  // flag positions inside the status word
  localparam int unsigned FL_C = 0;
  localparam int unsigned FL_Z = 1;
  localparam int unsigned FL_I = 2;
  localparam int unsigned FL_H = 3;
  localparam int unsigned FL_B = 4;
  localparam int unsigned FL_G = 5;
  localparam int unsigned FL_V = 6;
  localparam int unsigned FL_N = 7;

  localparam int unsigned NUM_FLAGS = 8;
  localparam int unsigned NIBBLE_W  = 4;

endpackage

// File: rtl/cpu_status_alu.sv
module cpu_status_alu
  import cpu_status_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  op_e            op_i,
  input  logic [DW-1:0]  a_i,
  input  logic [DW-1:0]  b_i,
  input  logic           cin_i,
  input  logic [DW-1:0]  mem_i,
  output logic [DW-1:0]  res_o,
  output logic           c_o,
  output logic           h_o,
  output logic           v_o,
  output logic           n_o,
  output logic           z_o
);

  localparam int unsigned MSB = DW - 1;

  logic [DW:0]         sum_w;
  logic [DW:0]         diff_w;
  logic [NIBBLE_W:0]   lo_sum_w;

  assign sum_w    = {1'b0, a_i} + {1'b0, b_i};
  assign diff_w   = {1'b0, a_i} - {1'b0, b_i};
  assign lo_sum_w = {1'b0, a_i[NIBBLE_W-1:0]} + {1'b0, b_i[NIBBLE_W-1:0]};

  always_comb begin
    res_o = a_i;
    c_o   = 1'b0;
    h_o   = 1'b0;
    v_o   = 1'b0;
    unique case (op_i)
      OP_ADD: begin
        res_o = sum_w[DW-1:0];
        c_o   = sum_w[DW];
        h_o   = lo_sum_w[NIBBLE_W];
        v_o   = (a_i[MSB] == b_i[MSB]) && (sum_w[MSB] != a_i[MSB]);
      end
      OP_SUB: begin
        res_o = diff_w[DW-1:0];
        c_o   = ~diff_w[DW];
        h_o   = (a_i[NIBBLE_W-1:0] >= b_i[NIBBLE_W-1:0]);
        v_o   = (a_i[MSB] != b_i[MSB]) && (diff_w[MSB] != a_i[MSB]);
      end
      OP_SHL: begin
        res_o = {a_i[DW-2:0], 1'b0};
        c_o   = a_i[MSB];
      end
      OP_SHR: begin
        res_o = {1'b0, a_i[DW-1:1]};
        c_o   = a_i[0];
      end
      OP_ROL: begin
        res_o = {a_i[DW-2:0], cin_i};
        c_o   = a_i[MSB];
      end
      OP_BIT:  res_o = a_i & mem_i;
      default: res_o = a_i;
    endcase
  end

  assign n_o = res_o[MSB];
  assign z_o = (res_o == '0);

  // R3: carry after subtract means no unsigned borrow
  always_comb begin
    if (op_i == OP_SUB) begin
      a_r3_sub_no_borrow: assert (c_o == (a_i >= b_i));
    end
    // R2: add result plus carry rebuilds the wide sum
    if (op_i == OP_ADD) begin
      a_r2_add_sum: assert ({c_o, res_o} == ({1'b0, a_i} + {1'b0, b_i}));
    end
  end

endmodule

// File: rtl/cpu_status_flags.sv
module cpu_status_flags
  import cpu_status_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  op_valid_i,
  input  op_e                   op_i,
  input  logic                  c_i,
  input  logic                  h_i,
  input  logic                  v_i,
  input  logic                  n_i,
  input  logic                  z_i,
  input  logic [DW-1:0]         mem_i,
  input  logic                  irq_accept_i,
  output logic [NUM_FLAGS-1:0]  flags_o
);

  localparam int unsigned MSB = DW - 1;

  logic [NUM_FLAGS-1:0] flags_q;
  logic [NUM_FLAGS-1:0] flags_d;

  always_comb begin
    flags_d = flags_q;
    if (op_valid_i) begin
      unique case (op_i)
        OP_ADD, OP_SUB: begin
          flags_d[FL_C] = c_i;
          flags_d[FL_V] = v_i;
          flags_d[FL_N] = n_i;
          flags_d[FL_Z] = z_i;
          flags_d[FL_H] = flags_q[FL_H] | h_i;
        end
        OP_SHL, OP_SHR, OP_ROL: begin
          flags_d[FL_C] = c_i;
          flags_d[FL_N] = n_i;
          flags_d[FL_Z] = z_i;
        end
        OP_MOV: begin
          flags_d[FL_N] = n_i;
          flags_d[FL_Z] = z_i;
        end
        OP_BIT: begin
          flags_d[FL_N] = mem_i[MSB];
          flags_d[FL_V] = mem_i[MSB-1];
          flags_d[FL_Z] = z_i;
        end
        OP_EI:   flags_d[FL_I] = 1'b1;
        OP_DI:   flags_d[FL_I] = 1'b0;
        OP_SETG: flags_d[FL_G] = 1'b1;
        OP_CLRG: flags_d[FL_G] = 1'b0;
        OP_CLRV: begin
          flags_d[FL_V] = 1'b0;
          flags_d[FL_H] = 1'b0;
        end
        OP_BRK:  flags_d[FL_B] = 1'b1;
        default: flags_d = flags_q;
      endcase
    end
    if (irq_accept_i) flags_d[FL_I] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

  assign flags_o = flags_q;

  a_r8_accept_clears_i: assert property (@(posedge clk) disable iff (!rst_n)
    irq_accept_i |=> !flags_q[FL_I]);

  a_r9_h_cleared_by_clrv_only: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_q[FL_H] && !(op_valid_i && op_i == OP_CLRV)) |=> flags_q[FL_H]);

  a_r11_break_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    flags_q[FL_B] |=> flags_q[FL_B]);

  a_r10_setg_sets_page: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid_i && op_i == OP_SETG) |=> flags_q[FL_G]);

  a_r12_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_valid_i && !irq_accept_i) |=> $stable(flags_q));

endmodule

// File: rtl/cpu_status_reg.sv
module cpu_status_reg
  import cpu_status_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  input  logic [3:0]    op_code,
  input  logic [DW-1:0] opnd_a,
  input  logic [DW-1:0] opnd_b,
  input  logic          rot_cin,
  input  logic [DW-1:0] mem_byte,
  input  logic          irq_accept,
  output logic [NUM_FLAGS-1:0] status,
  output logic [DW-1:0] result,
  output logic          irq_gate,
  output logic          dp_page_bit
);

  op_e  op_w;
  logic c_w, h_w, v_w, n_w, z_w;

  assign op_w = op_e'(op_code);

  cpu_status_alu #(.DW(DW)) u_alu (
    .op_i  (op_w),
    .a_i   (opnd_a),
    .b_i   (opnd_b),
    .cin_i (rot_cin),
    .mem_i (mem_byte),
    .res_o (result),
    .c_o   (c_w),
    .h_o   (h_w),
    .v_o   (v_w),
    .n_o   (n_w),
    .z_o   (z_w)
  );

  cpu_status_flags #(.DW(DW)) u_flags (
    .clk          (clk),
    .rst_n        (rst_n),
    .op_valid_i   (op_valid),
    .op_i         (op_w),
    .c_i          (c_w),
    .h_i          (h_w),
    .v_i          (v_w),
    .n_i          (n_w),
    .z_i          (z_w),
    .mem_i        (mem_byte),
    .irq_accept_i (irq_accept),
    .flags_o      (status)
  );

  assign irq_gate    = status[FL_I];
  assign dp_page_bit = status[FL_G];

endmodule

// File: tb/cpu_status_reg_bench.sv
module cpu_status_reg_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_valid = 1'b0;
  logic [3:0] op_code = 4'h0;
  logic [7:0] opnd_a = 8'h00;
  logic [7:0] opnd_b = 8'h00;
  logic       rot_cin = 1'b0;
  logic [7:0] mem_byte = 8'h00;
  logic       irq_accept = 1'b0;
  logic [7:0] status;
  logic [7:0] result;
  logic       irq_gate;
  logic       dp_page_bit;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  cpu_status_reg u_cpu_status_reg (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .rot_cin(rot_cin), .mem_byte(mem_byte),
    .irq_accept(irq_accept), .status(status), .result(result),
    .irq_gate(irq_gate), .dp_page_bit(dp_page_bit)
  );

  // fields: op, a, b, cin, mem, expected result, expected status after edge
  localparam int NV = 22;
  localparam logic [44:0] VECS [NV] = '{
    {4'h1, 8'h0F, 8'h01, 1'b0, 8'h00, 8'h10, 8'h08}, // R2 nibble carry
    {4'h1, 8'h7F, 8'h01, 1'b0, 8'h00, 8'h80, 8'hC8}, // R2 signed overflow
    {4'h1, 8'hFF, 8'h01, 1'b0, 8'h00, 8'h00, 8'h0B}, // R2 wrap, carry
    {4'hC, 8'h00, 8'h00, 1'b0, 8'h00, 8'h00, 8'h03}, // R9 clrv
    {4'h2, 8'h10, 8'h01, 1'b0, 8'h00, 8'h0F, 8'h01}, // R3 nibble borrow
    {4'h2, 8'h05, 8'h05, 1'b0, 8'h00, 8'h00, 8'h0B}, // R3 equal
    {4'h2, 8'h80, 8'h01, 1'b0, 8'h00, 8'h7F, 8'h49}, // R3 overflow
    {4'h2, 8'h00, 8'h01, 1'b0, 8'h00, 8'hFF, 8'h88}, // R3 borrow
    {4'h3, 8'h81, 8'h00, 1'b0, 8'h00, 8'h02, 8'h09}, // R4 shl
    {4'h5, 8'h40, 8'h00, 1'b1, 8'h00, 8'h81, 8'h88}, // R4 rol
    {4'h4, 8'h01, 8'h00, 1'b0, 8'h00, 8'h00, 8'h0B}, // R4 shr
    {4'h6, 8'h00, 8'h00, 1'b0, 8'h00, 8'h00, 8'h0B}, // R5 zero
    {4'h6, 8'h9C, 8'h00, 1'b0, 8'h00, 8'h9C, 8'h89}, // R5 negative
    {4'h7, 8'h0F, 8'h00, 1'b0, 8'hC0, 8'h00, 8'hCB}, // R6 copy
    {4'h7, 8'hFF, 8'h00, 1'b0, 8'h01, 8'h01, 8'h09}, // R6 nonzero
    {4'h8, 8'h00, 8'h00, 1'b0, 8'h00, 8'h00, 8'h0D}, // R7 ei
    {4'hA, 8'h00, 8'h00, 1'b0, 8'h00, 8'h00, 8'h2D}, // R10 setg
    {4'hD, 8'h00, 8'h00, 1'b0, 8'h00, 8'h00, 8'h3D}, // R11 brk
    {4'h9, 8'h00, 8'h00, 1'b0, 8'h00, 8'h00, 8'h39}, // R7 di
    {4'hB, 8'h00, 8'h00, 1'b0, 8'h00, 8'h00, 8'h19}, // R10 clrg
    {4'hC, 8'h00, 8'h00, 1'b0, 8'h00, 8'h00, 8'h11}, // R9 clrv
    {4'h0, 8'h00, 8'h00, 1'b0, 8'h00, 8'h00, 8'h11}  // R12 nop
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic apply(input logic v, input logic [3:0] op, input logic [7:0] a,
                       input logic [7:0] b, input logic cin, input logic [7:0] m,
                       input logic acc);
    @(negedge clk);
    op_valid = v; op_code = op; opnd_a = a; opnd_b = b;
    rot_cin = cin; mem_byte = m; irq_accept = acc;
  endtask

  task automatic settle();
    @(posedge clk);
    #2;
    op_valid = 1'b0; irq_accept = 1'b0;
  endtask

  initial begin
    #200000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check("R1 reset status", status, 8'h00);
    check("R1 reset gates", {6'd0, irq_gate, dp_page_bit}, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      apply(1'b1, VECS[i][44:41], VECS[i][40:33], VECS[i][32:25], VECS[i][24],
            VECS[i][23:16], 1'b0);
      #2;
      check($sformatf("R2-table vec %0d result", i), result, VECS[i][15:8]);
      settle();
      check($sformatf("R2-table vec %0d status", i), status, VECS[i][7:0]);
    end

    // R12: idle holds even with a live-looking op on the pins
    apply(1'b0, 4'hC, 8'h00, 8'h00, 1'b0, 8'h00, 1'b0);
    settle();
    check("R12 idle hold", status, 8'h11);

    // R7: EI then gate high
    apply(1'b1, 4'h8, 8'h00, 8'h00, 1'b0, 8'h00, 1'b0);
    settle();
    check("R7 irq_gate after EI", {7'd0, irq_gate}, 8'h01);

    // R8: accept alone, no op
    apply(1'b0, 4'h0, 8'h00, 8'h00, 1'b0, 8'h00, 1'b1);
    settle();
    check("R8 accept clears I", status, 8'h11);

    // R8: accept wins over EI in the same cycle
    apply(1'b1, 4'h8, 8'h00, 8'h00, 1'b0, 8'h00, 1'b1);
    settle();
    check("R8 accept beats EI", {7'd0, irq_gate}, 8'h00);

    // R9: H set by add carry, then add without nibble carry keeps it
    apply(1'b1, 4'h1, 8'h08, 8'h08, 1'b0, 8'h00, 1'b0);
    settle();
    check("R9 add sets H", status, 8'h18);
    apply(1'b1, 4'h1, 8'h01, 8'h01, 1'b0, 8'h00, 1'b0);
    settle();
    check("R9 H kept", status, 8'h18);
    apply(1'b1, 4'h6, 8'h00, 8'h00, 1'b0, 8'h00, 1'b0);
    settle();
    check("R9 transfer keeps H", status, 8'h1A);

    // R10: page bit output
    apply(1'b1, 4'hA, 8'h33, 8'h00, 1'b0, 8'h00, 1'b0);
    #2;
    check("R12 control result is operand a", result, 8'h33);
    settle();
    check("R10 dp_page_bit", {7'd0, dp_page_bit}, 8'h01);

    // R11: break survives clrv and di
    apply(1'b1, 4'hC, 8'h00, 8'h00, 1'b0, 8'h00, 1'b0);
    settle();
    check("R11 break kept", status, 8'h32);

    // R1: reset in mid-run clears everything
    @(negedge clk);
    rst_n = 1'b0;
    #2;
    check("R1 async reset", status, 8'h00);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule